// File: doc/BRIEF.md
# Radix-4 Booth Multiplier Sequencer

This block is the control sequencer for a serial radix-4 Booth multiplier. It holds a 3-bit binary state register and drives that state onto a bus so the arithmetic datapath can decode it. The datapath uses the state to pick its action on each cycle: capture the multiplicand, capture the multiplier, then apply four recoded partial-product additions, each followed by a two-bit shift.

A single start input begins a multiplication. The block looks at start only while it is idle and while it is holding a finished result. In every other state it advances on each clock without condition. From the finished state, a start pulse goes straight back to multiplicand capture, so back-to-back products never pass through idle. A synchronous reset returns the sequencer to idle from any state.

Top module: `booth_seq_ctrl`

## Requirements
- R1: The encoding is fixed: idle = 3'b000, multiplicand capture = 3'b001, multiplier capture = 3'b010, add/shift steps = 3'b011, 3'b100, 3'b101 and 3'b110, finished = 3'b111. `state_o` always shows the registered state.
- R2: In idle, with `start_i` low, the state stays at 3'b000 on the next edge.
- R3: In idle, with `start_i` high, the state moves to 3'b001 on the next edge.
- R4: From states 3'b001 through 3'b110, the state advances to the next binary code on every edge, whatever the value of `start_i`.
- R5: In the finished state 3'b111, with `start_i` low, the state holds.
- R6: In the finished state, with `start_i` high, the state moves directly to 3'b001.
- R7: `rst_i` is sampled on the rising edge and forces the state to 3'b000 from any state, even when `start_i` is high.
- R8: `done_o` is high exactly when the state is 3'b111. `mcand_ld_o` is high exactly when the state is 3'b001. Both are decoded from the state register alone.
- R9: `done_o` falls on the same edge that takes the state out of 3'b111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begins a multiplication; only used in idle and finished |
| state_o | output | 3 | Current sequencer state for the datapath |
| done_o | output | 1 | Product complete (state 3'b111) |
| mcand_ld_o | output | 1 | Multiplicand register load enable (state 3'b001) |

## Verification
The clocked properties assume that `rst_i` and `start_i` are settled and known at every rising edge. They also assume reset is applied on the first edge, so the state register is never examined in an unknown state. The bench changes both inputs only on falling edges and holds reset high for the opening cycles. It also drives `start_i` high and low during the capture and add/shift states, to show that the input is ignored there, and it asserts reset together with `start_i` to exercise the override.

// File: rtl/booth_seq_pkg.sv
package booth_seq_pkg;
    localparam int unsigned STATE_W = 3;
    localparam int unsigned ADD_STEPS = 4;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE   = 3'b000,
        ST_LD_MC  = 3'b001,
        ST_LD_MP  = 3'b010,
        ST_ADD0   = 3'b011,
        ST_ADD1   = 3'b100,
        ST_ADD2   = 3'b101,
        ST_ADD3   = 3'b110,
        ST_FINISH = 3'b111
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
    } seq_regs_t;
endpackage

// File: rtl/booth_seq_next.sv
module booth_seq_next
    import booth_seq_pkg::*;
(
    input  seq_state_e cur_i,
    input  logic       start_i,
    output seq_state_e nxt_o
);
    always_comb begin
        unique case (cur_i)
            ST_IDLE:   nxt_o = start_i ? ST_LD_MC : ST_IDLE;
            ST_FINISH: nxt_o = start_i ? ST_LD_MC : ST_FINISH;
            default:   nxt_o = seq_state_e'(cur_i + 3'd1);
        endcase
    end
endmodule

// File: rtl/booth_seq_decode.sv
module booth_seq_decode
    import booth_seq_pkg::*;
(
    input  seq_state_e st_i,
    output logic       done_o,
    output logic       mcand_ld_o
);
    always_comb begin
        done_o     = (st_i == ST_FINISH);
        mcand_ld_o = (st_i == ST_LD_MC);
    end
endmodule

// File: rtl/booth_seq_ctrl.sv
module booth_seq_ctrl
    import booth_seq_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               start_i,
    output logic [STATE_W-1:0] state_o,
    output logic               done_o,
    output logic               mcand_ld_o
);
    seq_regs_t  regs_d, regs_q;
    seq_state_e step_nxt;

    booth_seq_next u_next (
        .cur_i   (regs_q.st),
        .start_i (start_i),
        .nxt_o   (step_nxt)
    );

    booth_seq_decode u_dec (
        .st_i       (regs_q.st),
        .done_o     (done_o),
        .mcand_ld_o (mcand_ld_o)
    );

    always_comb begin
        regs_d = regs_q;
        if (rst_i) begin
            regs_d.st = ST_IDLE;
        end else begin
            regs_d.st = step_nxt;
        end
    end

    always_ff @(posedge clk_i) begin
        regs_q <= regs_d;
    end

    assign state_o = regs_q.st;

    // Reset dominates start.
    assert_reset_idle_R7: assert property (@(posedge clk_i)
        rst_i |=> (state_o == 3'b000));

    assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (regs_q.st == ST_IDLE && !start_i) |=> (state_o == 3'b000));

    assert_idle_go_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (regs_q.st == ST_IDLE && start_i) |=> (state_o == 3'b001));

    assert_mid_advance_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (regs_q.st != ST_IDLE && regs_q.st != ST_FINISH)
        |=> (state_o == $past(state_o) + 3'd1));

    assert_finish_hold_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (regs_q.st == ST_FINISH && !start_i) |=> done_o);

    assert_finish_restart_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (regs_q.st == ST_FINISH && start_i) |=> (mcand_ld_o && !done_o));

    assert_flags_excl_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({done_o, mcand_ld_o}));

    assert_done_fall_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(done_o) |-> ($past(state_o) == 3'b111));
endmodule

// File: tb/tb_booth_seq_ctrl.sv
`timescale 1ns/1ps
module tb_booth_seq_ctrl;
    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic [2:0] state;
    logic       done;
    logic       ld;

    typedef struct {
        logic [2:0] st;
        string      tag;
    } exp_t;

    exp_t       sb_q[$];
    int         n_run  = 0;
    int         n_fail = 0;
    logic [2:0] model  = 3'b000;

    always #2.5 clk = ~clk;

    booth_seq_ctrl dut (
        .clk_i      (clk),
        .rst_i      (rst),
        .start_i    (start),
        .state_o    (state),
        .done_o     (done),
        .mcand_ld_o (ld)
    );

    function automatic logic [2:0] nxt(logic [2:0] s, logic r, logic g);
        if (r) return 3'b000;
        if (s == 3'b000) return g ? 3'b001 : 3'b000;
        if (s == 3'b111) return g ? 3'b001 : 3'b111;
        return s + 3'd1;
    endfunction

    task automatic step(input logic r, input logic g);
        exp_t e;
        string t;
        @(negedge clk);
        rst   = r;
        start = g;
        if (r) t = "R7";
        else if (model == 3'b000) t = g ? "R3" : "R2";
        else if (model == 3'b111) t = g ? "R6" : "R5";
        else t = "R4";
        model = nxt(model, r, g);
        e.st  = model;
        e.tag = t;
        sb_q.push_back(e);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // monitor: compares just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                chk(state == e.st, {e.tag, "/R1 state"}, state, e.st);
                chk(done == (e.st == 3'b111), "R8 done", done, e.st == 3'b111);
                chk(ld == (e.st == 3'b001), "R8 load", ld, e.st == 3'b001);
                if (e.tag == "R6") chk(!done, "R9 done falls", done, 0);
            end
        end
    end

    initial begin
        #(200000 * 5.0);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        start = 1'b0;
        step(1, 0); step(1, 1);                  // R7 reset state, override
        for (int i = 0; i < 3; i++) step(0, 0);  // R2
        step(0, 1);                              // R3
        for (int i = 0; i < 6; i++) step(0, i[0]); // R4 start toggled
        for (int i = 0; i < 3; i++) step(0, 0);  // R5
        step(0, 1);                              // R6, R9
        for (int i = 0; i < 6; i++) step(0, 1);  // R4 start held
        step(0, 1);                              // R6 again
        step(0, 0); step(0, 1);                  // R4 in LD_MP/ADD0
        step(1, 1);                              // R7 mid-run
        step(0, 0);
        step(0, 1);
        for (int i = 0; i < 6; i++) step(0, 0);
        step(1, 1);                              // R7 from finish
        for (int i = 0; i < 10; i++) step(0, 1); // continuous loop
        @(negedge clk); @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule